// File: doc/BRIEF.md
# Quantized Quadrature Sine Oscillator

This block is a numerically controlled oscillator that emits one sine sample and one cosine sample on every enabled clock. The output frequency is set by a phase step presented on `step`. A wide phase register advances by that step on each enabled cycle and wraps at its full range. Only the top bits of that register shape the output, so a fine frequency step costs no extra width in the amplitude path.

The amplitude path folds the phase into one quarter wave. Within that quarter, the position maps linearly to an amplitude level, which on its own would trace a triangle. A correction computed at elaboration is then added for each level, and the result lands on a rounded sine. The cosine uses the complement of the same folded index and takes its sign from two phase bits, so no second phase path is needed. Both outputs are sign-and-magnitude words, and both are registered.

Top module: `quad_sine_nco`

## Requirements
- R1: While `rst_n` is low, the phase is cleared to zero and `sin_q` and `cos_q` read 8'h00.
- R2: On each rising edge with `en` high, the 18-bit phase becomes (phase + `step`) mod 2^18.
- R3: On a rising edge with `en` low, the phase, `sin_q` and `cos_q` all keep their values, whatever `step` is.
- R4: On an enabled edge, `sin_q` and `cos_q` take the values derived from the phase held before that edge. After reset, the first enabled edge therefore shows phase zero: `sin_q`=8'h01 and `cos_q`=8'h7F.
- R5: Output format: bit 7 is the sign (1 = negative) and bits 6:0 are the magnitude. The sine sign is phase bit 17.
- R6: With phase bit 16 clear, the sine index k is phase[15:9]. With bit 16 set, k is the bitwise inverse of phase[15:9]. The sine magnitude is round(127*sin((k+0.5)*pi/256)).
- R7: The magnitude is the linear level k plus a non-negative per-level correction, and the sum never exceeds 127. Phase bits 8:0 have no effect on either output.
- R8: The cosine magnitude is the same formula applied to index 127-k, which is the bitwise inverse of k.
- R9: The cosine sign is phase bit 17 XOR phase bit 16.
- R10: A step at or near 2^18 wraps the phase, so the output moves backwards through the wave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance phase and update outputs |
| step | input | 18 | Phase increment per enabled cycle |
| sin_q | output | 8 | Sine sample, sign and 7-bit magnitude |
| cos_q | output | 8 | Cosine sample, sign and 7-bit magnitude |

## Verification
The assertions check the following on every cycle:
- the phase advances by exactly the step on an enabled edge;
- the phase and both outputs hold while `en` is low;
- the two output signs follow the pre-edge phase bits;
- the per-level correction never carries past the magnitude width.

Some behaviour only the bench scenarios can show. These are the exact magnitude values across all 512 folded positions, the mirrored indexing on falling quarters, the complemented cosine index, the latency after reset, and the backward walk produced by a wrapping step. The bench compares each of these against a model that uses a real sine function.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Odd power series for sin(x), for x in [0, pi/2]; evaluated only at elaboration.
   function automatic real sine_series(input real x);
      real term;
      real acc;
      acc  = x;
      term = x;
      for (int n = 1; n < 10; n++) begin
         term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
         acc  = acc + term;
      end
      return acc;
   endfunction

   // Rounded quarter-wave level for position k, sampled at the midpoint of its phase bin.
   function automatic int ideal_level(input int k, input int pos_w);
      real full_scale;
      real angle;
      full_scale = real'((1 << pos_w) - 1);
      angle      = (real'(k) + 0.5) * 3.14159265358979323846 / (2.0 * real'(1 << pos_w));
      return $rtoi(full_scale * sine_series(angle) + 0.5);
   endfunction

   // Correction added to the linear level k.
   function automatic int level_corr(input int k, input int pos_w);
      return ideal_level(k, pos_w) - k;
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PHASE_W-1:0] step,
   output logic [PHASE_W-1:0] phase
);

   if (PHASE_W < 4) begin : g_bad_width
      $error("nco_phase_acc: PHASE_W must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  phase <= '0;
      else if (en) phase <= phase + step;
   end

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> phase == PHASE_W'($past(phase) + $past(step))); // R2

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(phase)); // R3

endmodule

// File: rtl/nco_fold.sv
module nco_fold #(
   parameter int TRUNC_W = 9,
   localparam int POS_W  = TRUNC_W - 2
) (
   input  logic [TRUNC_W-1:0] trunc,
   output logic               sin_neg,
   output logic               cos_neg,
   output logic [POS_W-1:0]   sin_idx,
   output logic [POS_W-1:0]   cos_idx
);

   if (TRUNC_W < 3) begin : g_bad_width
      $error("nco_fold: TRUNC_W must be at least 3");
   end

   logic             half_bit;
   logic             slope_bit;
   logic [POS_W-1:0] pos;

   assign half_bit  = trunc[TRUNC_W-1];
   assign slope_bit = trunc[TRUNC_W-2];
   assign pos       = trunc[POS_W-1:0];

   always_comb begin
      sin_neg = half_bit;
      cos_neg = half_bit ^ slope_bit;
      sin_idx = slope_bit ? ~pos : pos;
      cos_idx = ~sin_idx;
   end

endmodule

// File: rtl/nco_quarter_map.sv
module nco_quarter_map #(
   parameter int POS_W   = 7,
   parameter bit CORRECT = 1'b1,
   localparam int LEVELS = 1 << POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] idx,
   output logic [POS_W-1:0] mag
);

   if (POS_W < 1 || POS_W > 10) begin : g_bad_width
      $error("nco_quarter_map: POS_W out of range");
   end

   logic [POS_W-1:0] corr_tab [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_tab
      if (CORRECT) begin : g_sine
         localparam int CORR = nco_pkg::level_corr(g, POS_W);
         if (CORR < 0 || CORR + g >= LEVELS) begin : g_bad_corr
            $error("nco_quarter_map: correction out of range");
         end
         assign corr_tab[g] = POS_W'(CORR);
      end else begin : g_triangle
         assign corr_tab[g] = '0;
      end
   end

   logic [POS_W:0] sum_w;
   assign sum_w = {1'b0, idx} + {1'b0, corr_tab[idx]};
   assign mag   = sum_w[POS_W-1:0];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_w[POS_W]); // R7

endmodule

// File: rtl/quad_sine_nco.sv
module quad_sine_nco #(
   parameter int PHASE_W = 18,
   parameter int TRUNC_W = 9,
   parameter bit CORRECT = 1'b1,
   localparam int POS_W  = TRUNC_W - 2,
   localparam int OUT_W  = POS_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PHASE_W-1:0] step,
   output logic [OUT_W-1:0]   sin_q,
   output logic [OUT_W-1:0]   cos_q
);

   if (TRUNC_W > PHASE_W) begin : g_bad_trunc
      $error("quad_sine_nco: TRUNC_W must not exceed PHASE_W");
   end

   logic [PHASE_W-1:0] phase;
   logic               sin_neg, cos_neg;
   logic [POS_W-1:0]   sin_idx, cos_idx;
   logic [POS_W-1:0]   sin_mag, cos_mag;

   nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(en), .step(step), .phase(phase)
   );

   nco_fold #(.TRUNC_W(TRUNC_W)) u_fold (
      .trunc  (phase[PHASE_W-1 -: TRUNC_W]),
      .sin_neg(sin_neg),
      .cos_neg(cos_neg),
      .sin_idx(sin_idx),
      .cos_idx(cos_idx)
   );

   nco_quarter_map #(.POS_W(POS_W), .CORRECT(CORRECT)) u_map_sin (
      .clk(clk), .rst_n(rst_n), .idx(sin_idx), .mag(sin_mag)
   );

   nco_quarter_map #(.POS_W(POS_W), .CORRECT(CORRECT)) u_map_cos (
      .clk(clk), .rst_n(rst_n), .idx(cos_idx), .mag(cos_mag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sin_q <= '0;
         cos_q <= '0;
      end else if (en) begin
         sin_q <= {sin_neg, sin_mag};
         cos_q <= {cos_neg, cos_mag};
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(sin_q) && $stable(cos_q)); // R3

   AST_SIN_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> sin_q[OUT_W-1] == $past(phase[PHASE_W-1])); // R5

   AST_COS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> cos_q[OUT_W-1] == ($past(phase[PHASE_W-1]) ^ $past(phase[PHASE_W-2]))); // R9

endmodule

// File: tb/sim_quad_sine_nco.sv
module sim_quad_sine_nco;

   localparam int CLK_PERIOD = 10;
   localparam int PMASK      = (1 << 18) - 1;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [17:0] step = '0;
   logic [7:0]  sin_q, cos_q;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   int mdl_p    = 0;
   bit done     = 1'b0;

   quad_sine_nco u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .step(step), .sin_q(sin_q), .cos_q(cos_q)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic int level(input int k);
      return $rtoi(127.0 * $sin((real'(k) + 0.5) * 3.14159265358979 / 256.0) + 0.5);
   endfunction

   function automatic logic [7:0] exp_sin(input int p);
      int t, pos, k;
      t   = (p >> 9) & 511;
      pos = t & 127;
      k   = ((t >> 7) & 1) ? 127 - pos : pos;
      return {1'(t >> 8), 7'(level(k))};
   endfunction

   function automatic logic [7:0] exp_cos(input int p);
      int t, pos, k;
      t   = (p >> 9) & 511;
      pos = t & 127;
      k   = ((t >> 7) & 1) ? 127 - pos : pos;
      return {1'((t >> 8) ^ (t >> 7)), 7'(level(127 - k))};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   // one clock: drive at negedge, model the edge, compare at the next negedge
   task automatic tick(input string tag, input bit e, input int s);
      logic [7:0] es, ec;
      en   = e;
      step = 18'(s);
      @(posedge clk);
      if (e) begin
         es    = exp_sin(mdl_p);
         ec    = exp_cos(mdl_p);
         mdl_p = (mdl_p + s) & PMASK;
      end else begin
         es = sin_q;
         ec = cos_q;
      end
      @(negedge clk);
      check({tag, " sin"}, sin_q, es);
      check({tag, " cos"}, cos_q, ec);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      en    = 1'b0;
      mdl_p = 0;
      repeat (2) @(negedge clk);
      check("R1 reset sin", sin_q, 8'h00);
      check("R1 reset cos", cos_q, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_first_sample();
      do_reset();
      en = 1'b1; step = 18'h2A000;
      @(posedge clk); @(negedge clk);
      check("R4 first sin", sin_q, 8'h01);
      check("R4 first cos", cos_q, 8'h7F);
      mdl_p = 18'h2A000;
      tick("R2/R4 second", 1'b1, 18'h00200);
   endtask

   task automatic t_low_bits();
      do_reset();
      for (int i = 0; i < 20; i++) tick("R7 sub-bin", 1'b1, 23);
      check("R7 low bits sin", sin_q, 8'h01);
      check("R7 low bits cos", cos_q, 8'h7F);
   endtask

   task automatic t_full_walk();
      do_reset();
      for (int i = 0; i < 520; i++) tick("R5/R6/R8/R9 walk", 1'b1, 512);
   endtask

   task automatic t_hold();
      logic [7:0] hs, hc;
      do_reset();
      for (int i = 0; i < 37; i++) tick("R2 advance", 1'b1, 1733);
      hs = sin_q; hc = cos_q;
      for (int i = 0; i < 8; i++) tick("R3 hold", 1'b0, 40000 + i * 977);
      check("R3 held sin", sin_q, hs);
      check("R3 held cos", cos_q, hc);
      for (int i = 0; i < 4; i++) tick("R3 resume", 1'b1, 5000);
   endtask

   task automatic t_wrap();
      do_reset();
      tick("R10 start", 1'b1, PMASK + 1 - 512);
      tick("R10 back", 1'b1, PMASK + 1 - 512);
      check("R10 wrapped sin", sin_q, 8'h81);
      check("R10 wrapped cos", cos_q, 8'h7F);
      for (int i = 0; i < 300; i++) tick("R10 reverse", 1'b1, PMASK - 700);
   endtask

   task automatic t_mixed();
      do_reset();
      for (int i = 0; i < 400; i++)
         tick("R2/R3/R6 mixed", (i % 5) != 3, (i * 7919 + 333) & PMASK);
   endtask

   initial begin
      @(negedge clk);
      t_first_sample();
      t_low_bits();
      t_full_walk();
      t_hold();
      t_wrap();
      t_mixed();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule